// File: doc/BRIEF.md
# Device-Side DMA Request Handshake Engine

This block runs the data phase of a sector-oriented DMA command on the device side of a parallel disk interface. When a command starts, it loads the sector count and the direction. It then raises a request to the host only when its data buffer can hand over a word (device to host) or take one (host to device). The host answers with an acknowledge. While the acknowledge is held, one pulse of the host read or write strobe moves exactly one 16-bit word. The engine counts words within each sector and counts the sectors left. After the last word of the last sector it pulses a completion signal and raises a single interrupt request.

While a command is in progress the engine asserts an inhibit output. Neighbouring logic uses it to keep register chip selects and the 16-bit-port indication inactive. The acknowledge and both strobes arrive asynchronously and pass through a synchroniser. Strobes are acted on at their rising edge.

A strobe is treated as a protocol error and moves no data in two cases: it arrives with no acknowledge seen, or its direction does not match the command. The error flag stays set until the next command starts. The controller has six states:
- IDLE: waits for a start.
- WAIT: the buffer is not ready yet.
- REQ: the request is raised and no acknowledge has been seen.
- ACK: the acknowledge has been seen and the engine waits for a strobe.
- GAP: a word has been moved and the engine waits for the acknowledge to be released.
- END: a one-cycle completion state.

The transitions are:
- IDLE→WAIT when a start is accepted.
- WAIT→REQ when the buffer is ready.
- REQ→ACK when the acknowledge is seen.
- ACK→REQ when the acknowledge is withdrawn without a word.
- REQ/ACK→GAP when a word moves and words remain.
- REQ/ACK→END when the last word moves.
- GAP→WAIT when the acknowledge is released.
- END→IDLE unconditionally.

Top module: `dma_handshake_engine`

## Requirements
- R1: After reset, dma_req, fifo_pop, fifo_push, xfer_done, irq_req, proto_err and pio_inhibit are 0, and host_rdata is 0.
- R2: dma_req is raised only when the buffer is ready for the command direction. For a device-to-host command (cmd_to_host=1) that means buf_has_word=1. For a host-to-device command it means buf_has_room=1. dma_req stays 0 while the buffer is not ready.
- R3: Once raised, dma_req stays 1 until a word has been moved under a synchronised acknowledge, and then falls.
- R4: In a device-to-host command, a rising host_rd_stb while host_ack is held pulses fifo_pop once, and host_rdata then shows the word fifo_rdata carried at that pop.
- R5: In a host-to-device command, a rising host_wr_stb while host_ack is held pulses fifo_push once, with host_wdata on fifo_wdata. Words reach the buffer in strobe order.
- R6: A strobe rising with no acknowledge, or in the direction opposite to the command, moves no word and does not count. It also sets proto_err, which stays 1 until the next accepted cmd_start clears it.
- R7: A command moves cmd_sectors × WORDS_PER_SECTOR words, and cmd_sectors=0 stands for 256 sectors.
- R8: xfer_done is a single-cycle pulse after the last word of the last sector. irq_req becomes 1 at that point and holds until the next accepted cmd_start. Neither signal appears at earlier sector boundaries.
- R9: pio_inhibit is 1 from the accepted start until the command completes, and 0 when idle.
- R10: After a word is moved, dma_req is not raised again until the host releases the acknowledge, and only if words remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for a DMA command, accepted when idle |
| cmd_to_host | input | 1 | 1: device to host (read), 0: host to device (write) |
| cmd_sectors | input | SEC_W | Sector count; 0 stands for 2^SEC_W sectors |
| buf_has_word | input | 1 | Buffer holds at least one word to send |
| buf_has_room | input | 1 | Buffer can accept at least one word |
| fifo_rdata | input | DATA_W | Head word of the outgoing buffer |
| host_ack | input | 1 | Host acknowledge, asynchronous, active high |
| host_rd_stb | input | 1 | Host read strobe, asynchronous, active high |
| host_wr_stb | input | 1 | Host write strobe, asynchronous, active high |
| host_wdata | input | DATA_W | Word driven by the host on a write |
| dma_req | output | 1 | Request to the host |
| fifo_pop | output | 1 | Removes the head word of the outgoing buffer |
| fifo_push | output | 1 | Writes fifo_wdata into the incoming buffer |
| fifo_wdata | output | DATA_W | Word to store on fifo_push |
| host_rdata | output | DATA_W | Word captured for the host on the last pop |
| xfer_done | output | 1 | One-cycle pulse at command completion |
| irq_req | output | 1 | Interrupt request raised once per command |
| proto_err | output | 1 | Sticky flag for a strobe that was ignored |
| pio_inhibit | output | 1 | Keeps register selects and the 16-bit-port indication off |

## Verification
Each kind of fault in the state or counters shows up at the ports within a few cycles:
- A word counter that drifts by one makes xfer_done and irq_req appear one word early or late. That is visible at the last strobe of the command, or at the first sector boundary for a sector counter fault.
- A state machine that leaves REQ early drops dma_req before a word has moved.
- A state machine that skips GAP raises dma_req again while the acknowledge is still held. That appears within two clocks of the strobe.
- Wrong direction decoding pushes or pops on the wrong strobe. The scoreboard catches it as an unexpected buffer operation or a mismatched word in the same cycle.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_ACK,
        ST_GAP,
        ST_END
    } hs_state_e;

endpackage

// File: rtl/dma_hs_sync.sv
// Multi-stage synchroniser for asynchronous host handshake lines.
module dma_hs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign level_out = chain_q[STAGES-1];

endmodule

// File: rtl/dma_hs_edge.sv
// Rising-edge detector on already synchronised levels.
module dma_hs_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] rise_out
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_in;
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign rise_out[b] = lvl_in[b] & ~prev_q[b];
    end

endmodule

// File: rtl/dma_hs_counter.sv
// Word-in-sector index and sectors-remaining counter.
module dma_hs_counter #(
    parameter int WORDS_PER_SECTOR = 256,
    parameter int SEC_W            = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] sectors,
    input  logic             beat,
    output logic             last_word
);

    localparam int WIDX_W  = (WORDS_PER_SECTOR > 1) ? $clog2(WORDS_PER_SECTOR) : 1;
    localparam int SLEFT_W = SEC_W + 1;
    localparam logic [WIDX_W-1:0]  LAST_IDX = WIDX_W'(WORDS_PER_SECTOR - 1);
    localparam logic [SLEFT_W-1:0] ALL_SECS = SLEFT_W'(2 ** SEC_W);

    logic [WIDX_W-1:0]  word_idx_q;
    logic [SLEFT_W-1:0] sec_left_q;
    logic               sector_wrap;

    assign sector_wrap = (word_idx_q == LAST_IDX);
    assign last_word   = sector_wrap && (sec_left_q == SLEFT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx_q <= '0;
            sec_left_q <= '0;
        end else if (load) begin
            word_idx_q <= '0;
            sec_left_q <= (sectors == '0) ? ALL_SECS : {1'b0, sectors};
        end else if (beat) begin
            if (sector_wrap) begin
                word_idx_q <= '0;
                sec_left_q <= sec_left_q - SLEFT_W'(1);
            end else begin
                word_idx_q <= word_idx_q + WIDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/dma_hs_fsm.sv
// Request/acknowledge controller.
module dma_hs_fsm
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_to_host,
    input  logic buf_ready,
    input  logic ack_s,
    input  logic rd_rise,
    input  logic wr_rise,
    input  logic last_word,
    output logic cmd_dir,
    output logic load,
    output logic beat,
    output logic dma_req,
    output logic fifo_pop,
    output logic fifo_push,
    output logic xfer_done,
    output logic irq_req,
    output logic proto_err,
    output logic pio_inhibit
);

    hs_state_e state_q;
    hs_state_e state_d;
    logic      accept;
    logic      good_rise;
    logic      bad_rise;
    logic      move;
    logic      err_evt;

    always_comb begin
        accept    = (state_q == ST_IDLE) && cmd_start;
        good_rise = cmd_dir ? rd_rise : wr_rise;
        bad_rise  = cmd_dir ? wr_rise : rd_rise;
        move      = ack_s && good_rise && ((state_q == ST_REQ) || (state_q == ST_ACK));
        err_evt   = bad_rise || (good_rise && !move);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_WAIT;
            ST_WAIT: if (buf_ready) state_d = ST_REQ;
            ST_REQ: begin
                if (move)       state_d = last_word ? ST_END : ST_GAP;
                else if (ack_s) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (move)        state_d = last_word ? ST_END : ST_GAP;
                else if (!ack_s) state_d = ST_REQ;
            end
            ST_GAP:  if (!ack_s)    state_d = ST_WAIT;
            ST_END:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_dir   <= 1'b0;
            irq_req   <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            if (accept) begin
                cmd_dir <= cmd_to_host;
            end
            if (accept) begin
                irq_req <= 1'b0;
            end else if (state_q == ST_END) begin
                irq_req <= 1'b1;
            end
            if (err_evt) begin
                proto_err <= 1'b1;
            end else if (accept) begin
                proto_err <= 1'b0;
            end
        end
    end

    always_comb begin
        load        = accept;
        beat        = move;
        dma_req     = (state_q == ST_REQ) || (state_q == ST_ACK);
        fifo_pop    = move && cmd_dir;
        fifo_push   = move && !cmd_dir;
        xfer_done   = (state_q == ST_END);
        pio_inhibit = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/dma_handshake_engine.sv
module dma_handshake_engine #(
    parameter int WORDS_PER_SECTOR = 256,
    parameter int SEC_W            = 8,
    parameter int DATA_W           = 16,
    parameter int SYNC_STAGES      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_to_host,
    input  logic [SEC_W-1:0]  cmd_sectors,
    input  logic              buf_has_word,
    input  logic              buf_has_room,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              host_ack,
    input  logic              host_rd_stb,
    input  logic              host_wr_stb,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              dma_req,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              xfer_done,
    output logic              irq_req,
    output logic              proto_err,
    output logic              pio_inhibit
);

    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lvl;
    logic [1:0]         stb_rise;
    logic               ack_s;
    logic               rd_rise;
    logic               wr_rise;
    logic               cmd_dir;
    logic               buf_ready;
    logic               load;
    logic               beat;
    logic               last_word;

    assign raw_lines = {host_wr_stb, host_rd_stb, host_ack};

    dma_hs_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (raw_lines),
        .level_out (sync_lvl)
    );

    assign ack_s = sync_lvl[0];

    dma_hs_edge #(
        .WIDTH (2)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (sync_lvl[2:1]),
        .rise_out (stb_rise)
    );

    assign rd_rise   = stb_rise[0];
    assign wr_rise   = stb_rise[1];
    assign buf_ready = cmd_dir ? buf_has_word : buf_has_room;

    dma_hs_counter #(
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
        .SEC_W            (SEC_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .sectors   (cmd_sectors),
        .beat      (beat),
        .last_word (last_word)
    );

    dma_hs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_to_host (cmd_to_host),
        .buf_ready   (buf_ready),
        .ack_s       (ack_s),
        .rd_rise     (rd_rise),
        .wr_rise     (wr_rise),
        .last_word   (last_word),
        .cmd_dir     (cmd_dir),
        .load        (load),
        .beat        (beat),
        .dma_req     (dma_req),
        .fifo_pop    (fifo_pop),
        .fifo_push   (fifo_push),
        .xfer_done   (xfer_done),
        .irq_req     (irq_req),
        .proto_err   (proto_err),
        .pio_inhibit (pio_inhibit)
    );

    assign fifo_wdata = host_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (fifo_pop) begin
            host_rdata <= fifo_rdata;
        end
    end

endmodule

// File: rtl/dma_hs_checker.sv
module dma_hs_checker (
    input logic clk,
    input logic rst_n,
    input logic dma_req,
    input logic ack_s,
    input logic buf_ready,
    input logic cmd_dir,
    input logic fifo_push,
    input logic fifo_pop,
    input logic xfer_done,
    input logic irq_req,
    input logic pio_inhibit
);

    p_req_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(buf_ready));

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !ack_s) |=> dma_req);

    p_pop_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (cmd_dir && ack_s && dma_req));

    p_push_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (!cmd_dir && ack_s && dma_req));

    p_done_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(fifo_push || fifo_pop));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    p_irq_follows_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> irq_req);

    p_inhibit_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req || xfer_done) |-> pio_inhibit);

    p_no_rerequest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push || fifo_pop) |=> !dma_req);

endmodule

bind dma_handshake_engine dma_hs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_req     (dma_req),
    .ack_s       (ack_s),
    .buf_ready   (buf_ready),
    .cmd_dir     (cmd_dir),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .xfer_done   (xfer_done),
    .irq_req     (irq_req),
    .pio_inhibit (pio_inhibit)
);

// File: tb/dma_handshake_engine_test.sv
module dma_handshake_engine_test;

    localparam int WPS   = 4;
    localparam int SEC_W = 8;
    localparam int DW    = 16;
    localparam int MEM_N = 2048;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic             cmd_to_host = 1'b0;
    logic [SEC_W-1:0] cmd_sectors = '0;
    logic             buf_has_word;
    logic             buf_has_room = 1'b1;
    logic [DW-1:0]    fifo_rdata;
    logic             host_ack = 1'b0;
    logic             host_rd_stb = 1'b0;
    logic             host_wr_stb = 1'b0;
    logic [DW-1:0]    host_wdata = '0;
    logic             dma_req;
    logic             fifo_pop;
    logic             fifo_push;
    logic [DW-1:0]    fifo_wdata;
    logic [DW-1:0]    host_rdata;
    logic             xfer_done;
    logic             irq_req;
    logic             proto_err;
    logic             pio_inhibit;

    dma_handshake_engine #(
        .WORDS_PER_SECTOR (WPS),
        .SEC_W            (SEC_W),
        .DATA_W           (DW),
        .SYNC_STAGES      (2)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_to_host  (cmd_to_host),
        .cmd_sectors  (cmd_sectors),
        .buf_has_word (buf_has_word),
        .buf_has_room (buf_has_room),
        .fifo_rdata   (fifo_rdata),
        .host_ack     (host_ack),
        .host_rd_stb  (host_rd_stb),
        .host_wr_stb  (host_wr_stb),
        .host_wdata   (host_wdata),
        .dma_req      (dma_req),
        .fifo_pop     (fifo_pop),
        .fifo_push    (fifo_push),
        .fifo_wdata   (fifo_wdata),
        .host_rdata   (host_rdata),
        .xfer_done    (xfer_done),
        .irq_req      (irq_req),
        .proto_err    (proto_err),
        .pio_inhibit  (pio_inhibit)
    );

    // Outgoing buffer model
    logic [DW-1:0] src_mem [0:MEM_N-1];
    int            src_count = 0;
    int            rd_ptr = 0;
    logic          avail_rd = 1'b1;

    assign fifo_rdata   = (rd_ptr < MEM_N) ? src_mem[rd_ptr] : '0;
    assign buf_has_word = avail_rd && (rd_ptr < src_count);

    always @(posedge clk) begin
        if (fifo_pop) rd_ptr <= rd_ptr + 1;
    end

    // Scoreboard
    logic [DW-1:0] exp_wr [$];
    logic [DW-1:0] exp_rd [$];
    int checks = 0;
    int fails = 0;
    int push_cnt = 0;
    int pop_cnt = 0;
    int done_cnt = 0;
    int p_base = 0;
    int q_base = 0;
    int d_base = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (fifo_push) begin
            push_cnt++;
            if (exp_wr.size() == 0) begin
                chk("R6 unexpected buffer push", 32'd1, 32'd0);
            end else begin
                logic [DW-1:0] w;
                w = exp_wr.pop_front();
                chk("R5 pushed word", {16'h0, fifo_wdata}, {16'h0, w});
            end
        end
        if (fifo_pop)  pop_cnt++;
        if (xfer_done) done_cnt++;
    end

    task automatic wait_req(input logic want, input string tag);
        int n = 0;
        while (dma_req !== want && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {31'h0, dma_req}, {31'h0, want});
    endtask

    task automatic load_src(input int nw);
        for (int k = 0; k < nw; k++) begin
            logic [DW-1:0] v;
            v = DW'(16'hA000 ^ ((src_count + k) * 37));
            src_mem[src_count + k] = v;
            exp_rd.push_back(v);
        end
        src_count = src_count + nw;
    endtask

    task automatic start_cmd(input bit rd, input int sectors);
        p_base = push_cnt;
        q_base = pop_cnt;
        d_base = done_cnt;
        cmd_to_host = rd;
        cmd_sectors = SEC_W'(sectors);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R8 irq cleared by start", {31'h0, irq_req}, 32'd0);
        chk("R6 error flag cleared by start", {31'h0, proto_err}, 32'd0);
        chk("R9 inhibit during command", {31'h0, pio_inhibit}, 32'd1);
    endtask

    task automatic host_beat(input bit rd, input logic [DW-1:0] wd);
        wait_req(1'b1, "R2 request raised when ready");
        host_ack = 1'b1;
        host_wdata = wd;
        if (!rd) exp_wr.push_back(wd);
        repeat (3) @(negedge clk);
        chk("R3 request held under acknowledge", {31'h0, dma_req}, 32'd1);
        if (rd) host_rd_stb = 1'b1; else host_wr_stb = 1'b1;
        wait_req(1'b0, "R3 request released after word");
        if (rd) begin
            logic [DW-1:0] e;
            e = exp_rd.pop_front();
            chk("R4 read word", {16'h0, host_rdata}, {16'h0, e});
        end
        host_rd_stb = 1'b0;
        host_wr_stb = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 no request while ack held", {31'h0, dma_req}, 32'd0);
        host_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_beats(input bit rd, input int first, input int nw);
        for (int i = first; i < nw; i++) begin
            host_beat(rd, DW'(16'h5000 + i * 3));
            if (i < nw - 1) begin
                chk("R8 no done before last word", done_cnt, d_base);
                chk("R8 no irq before last word", {31'h0, irq_req}, 32'd0);
            end
        end
    endtask

    task automatic finish_cmd(input bit rd, input int nw);
        repeat (3) @(negedge clk);
        chk("R8 single done pulse", done_cnt, d_base + 1);
        chk("R8 irq raised at end", {31'h0, irq_req}, 32'd1);
        chk("R9 inhibit released", {31'h0, pio_inhibit}, 32'd0);
        if (rd) chk("R7 word count", pop_cnt - q_base, nw);
        else    chk("R7 word count", push_cnt - p_base, nw);
        repeat (6) @(negedge clk);
        chk("R8 no second done", done_cnt, d_base + 1);
        chk("R8 irq held", {31'h0, irq_req}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dma_req", {31'h0, dma_req}, 32'd0);
        chk("R1 push/pop", {30'h0, fifo_push, fifo_pop}, 32'd0);
        chk("R1 done/irq", {30'h0, xfer_done, irq_req}, 32'd0);
        chk("R1 proto_err/inhibit", {30'h0, proto_err, pio_inhibit}, 32'd0);
        chk("R1 host_rdata", {16'h0, host_rdata}, 32'd0);

        // Write, 2 sectors, with request hold test (R3)
        start_cmd(1'b0, 2);
        wait_req(1'b1, "R2 request with room");
        repeat (10) @(negedge clk);
        chk("R3 request held without acknowledge", {31'h0, dma_req}, 32'd1);
        run_beats(1'b0, 0, 2 * WPS);
        finish_cmd(1'b0, 2 * WPS);

        // Read, 1 sector: buffer empty, stray strobe, wrong direction strobe
        load_src(WPS);
        avail_rd = 1'b0;
        start_cmd(1'b1, 1);
        repeat (20) @(negedge clk);
        chk("R2 no request while buffer empty", {31'h0, dma_req}, 32'd0);
        host_rd_stb = 1'b1;
        repeat (4) @(negedge clk);
        host_rd_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 strobe without ack flags error", {31'h0, proto_err}, 32'd1);
        chk("R6 strobe without ack moves nothing", pop_cnt, q_base);
        avail_rd = 1'b1;
        wait_req(1'b1, "R2 request once buffer has word");
        host_ack = 1'b1;
        repeat (3) @(negedge clk);
        host_wr_stb = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 wrong direction keeps request", {31'h0, dma_req}, 32'd1);
        chk("R6 wrong direction no push", push_cnt, p_base);
        chk("R6 wrong direction no pop", pop_cnt, q_base);
        host_wr_stb = 1'b0;
        repeat (2) @(negedge clk);
        host_rd_stb = 1'b1;
        wait_req(1'b0, "R4 request released after read");
        begin
            logic [DW-1:0] e;
            e = exp_rd.pop_front();
            chk("R4 first read word", {16'h0, host_rdata}, {16'h0, e});
        end
        host_rd_stb = 1'b0;
        repeat (2) @(negedge clk);
        host_ack = 1'b0;
        @(negedge clk);
        run_beats(1'b1, 1, WPS);
        finish_cmd(1'b1, WPS);
        chk("R6 error flag sticky", {31'h0, proto_err}, 32'd1);

        // Write, 3 sectors, buffer full at first
        buf_has_room = 1'b0;
        start_cmd(1'b0, 3);
        repeat (20) @(negedge clk);
        chk("R2 no request while buffer full", {31'h0, dma_req}, 32'd0);
        buf_has_room = 1'b1;
        run_beats(1'b0, 0, 3 * WPS);
        finish_cmd(1'b0, 3 * WPS);

        // Read, sector count 0 means 256 sectors
        load_src(256 * WPS);
        start_cmd(1'b1, 0);
        run_beats(1'b1, 0, 256 * WPS);
        finish_cmd(1'b1, 256 * WPS);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule